// File: doc/BRIEF.md
# USB Device Power and Suspend Control Register

This block is the 8-bit power-management register of a USB device function. The CPU reaches it through a simple address, write-strobe and read-strobe port. The USB engine feeds it bus events: suspend detected, resume detected, reset signaling present, start-of-frame received and IN token received. The block answers with a traffic-inhibit level, the suspend state, a remote-wakeup drive enable, a one-cycle function soft reset, a one-cycle resume interrupt and the send decision for armed isochronous IN packets.

The bits do not behave like a plain register. The inhibit flag can be cleared by software but only hardware sets it. The suspend flag is read-only and changes only through bus events and resume sequences. The isochronous update mode can hold back armed IN data until a frame start arrives, and it answers an early IN token with a zero-length packet.

Bit layout at the register address (0x01 by default): bit 7 iso-update mode, bits 6:5 unused, bit 4 inhibit, bit 3 bus reset / soft reset, bit 2 resume, bit 1 suspended, bit 0 suspend-detect enable.

Top module: `usb_pwr_ctl`

## Requirements
- R1: Only an access whose address equals REG_ADDR reads or writes the register. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R2: Bits 6:5 always read as 0, and writing them has no effect. After reset the register reads 0x10.
- R3: Inhibit (bit 4) is 1 after reset. Writing 0 to it clears it. Writing 1 never sets it, so only a soft reset sets it again.
- R4: Writing 1 to bit 3 gives a one-cycle func_reset pulse and returns every stored bit to its reset value (register reads 0x10). Reading bit 3 returns the live bus_reset input.
- R5: The suspended flag (bit 1) is set one cycle after bus_suspend only when suspend-detect enable (bit 0) is 1 and inhibit is 0. In every other case bus_suspend is ignored. Writes to bit 1 have no effect.
- R6: Writing resume (bit 2) = 1 while suspended drives wakeup_drive high. A later write of resume = 0 clears suspended and gives a one-cycle resume_irq pulse.
- R7: Writing resume = 1 while not suspended leaves wakeup_drive low, and the bit reads back as 1. Clearing it afterwards raises no interrupt.
- R8: When bus_resume is seen while suspended and inhibit is 0, the next intreg_rd strobe clears suspended.
- R9: With iso-update = 0, an IN token for an armed packet gives iso_send in the same cycle.
- R10: With iso-update = 1, an IN token for an armed packet before any start-of-frame gives iso_zlp and not iso_send. After a start-of-frame, the next IN token gives iso_send. iso_hold stays high from arming until that start-of-frame.
- R11: While inhibit is 1, every bus event (suspend, resume, start-of-frame, IN token) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| reg_addr | input | ADDR_W | CPU register address |
| reg_wr | input | 1 | CPU write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rd | input | 1 | CPU read enable |
| reg_rdata | output | 8 | Read data; 0 when not selected |
| bus_suspend | input | 1 | Suspend condition detected on the bus |
| bus_resume | input | 1 | Resume signaling detected on the bus |
| bus_reset | input | 1 | Reset signaling present on the bus |
| sof_rx | input | 1 | Start-of-frame token received |
| in_tok | input | 1 | IN token received for the isochronous endpoint |
| iso_armed | input | 1 | An isochronous IN packet is ready |
| intreg_rd | input | 1 | Read strobe of the common interrupt register |
| usb_inhibit | output | 1 | Bus traffic ignored |
| suspended | output | 1 | Suspend state |
| wakeup_drive | output | 1 | Drive remote-wakeup resume signaling |
| func_reset | output | 1 | One-cycle function soft reset |
| resume_irq | output | 1 | One-cycle resume interrupt |
| iso_send | output | 1 | Send the armed packet on this IN token |
| iso_zlp | output | 1 | Answer this IN token with a zero-length packet |
| iso_hold | output | 1 | Armed packet is waiting for start-of-frame |

## Verification
The hardest states to reach are those that need several preconditions built up in order. One is the bus-detected resume path: inhibit must be cleared, detection enabled, suspend entered and a resume event latched before the interrupt-register read strobe has any effect. The other is the early IN token in iso-update mode, which needs an armed packet and must arrive before any start-of-frame. The stimulus table walks the register through this sequence one vector at a time and reads the register back after each step. Directed tests then build the isochronous setup and place the IN tokens on either side of a start-of-frame.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;
   localparam int DATA_W   = 8;
   localparam int B_ISO    = 7;
   localparam int B_INH    = 4;
   localparam int B_RST    = 3;
   localparam int B_RSM    = 2;
   localparam int B_SUSP   = 1;
   localparam int B_SUSEN  = 0;
   localparam logic [DATA_W-1:0] RST_VAL = 8'h10;
endpackage

// File: rtl/upc_ctrl_bits.sv
module upc_ctrl_bits
   import usb_pwr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wd_iso,
   input  logic wd_inh,
   input  logic wd_rst,
   input  logic wd_rsm,
   input  logic wd_susen,
   output logic iso_upd,
   output logic inhibit,
   output logic rsm_bit,
   output logic susen,
   output logic func_reset
);
   logic soft_rst;
   assign soft_rst = wr_hit && wd_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iso_upd    <= RST_VAL[B_ISO];
         inhibit    <= RST_VAL[B_INH];
         rsm_bit    <= RST_VAL[B_RSM];
         susen      <= RST_VAL[B_SUSEN];
         func_reset <= 1'b0;
      end else begin
         func_reset <= soft_rst;
         if (soft_rst) begin
            iso_upd <= RST_VAL[B_ISO];
            inhibit <= RST_VAL[B_INH];
            rsm_bit <= RST_VAL[B_RSM];
            susen   <= RST_VAL[B_SUSEN];
         end else if (wr_hit) begin
            iso_upd <= wd_iso;
            inhibit <= inhibit && wd_inh;
            rsm_bit <= wd_rsm;
            susen   <= wd_susen;
         end
      end
   end
endmodule

// File: rtl/upc_susp_fsm.sv
module upc_susp_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wd_rst,
   input  logic wd_rsm,
   input  logic susen,
   input  logic inhibit,
   input  logic bus_suspend,
   input  logic bus_resume,
   input  logic intreg_rd,
   output logic suspended,
   output logic wakeup_drive,
   output logic resume_irq
);
   logic res_seen;
   logic soft_rst, wk_start, wk_end, bus_wake, enter;

   assign soft_rst = wr_hit && wd_rst;
   assign wk_start = wr_hit && wd_rsm && suspended && !wakeup_drive;
   assign wk_end   = wr_hit && !wd_rsm && wakeup_drive;
   assign bus_wake = res_seen && intreg_rd;
   assign enter    = susen && !inhibit && bus_suspend && !suspended;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         suspended    <= 1'b0;
         wakeup_drive <= 1'b0;
         res_seen     <= 1'b0;
         resume_irq   <= 1'b0;
      end else if (soft_rst) begin
         suspended    <= 1'b0;
         wakeup_drive <= 1'b0;
         res_seen     <= 1'b0;
         resume_irq   <= 1'b0;
      end else begin
         resume_irq <= wk_end;
         if (wk_start)
            wakeup_drive <= 1'b1;
         else if (wk_end)
            wakeup_drive <= 1'b0;
         if (suspended && !inhibit && bus_resume)
            res_seen <= 1'b1;
         else if (bus_wake || !suspended)
            res_seen <= 1'b0;
         if (wk_end || bus_wake)
            suspended <= 1'b0;
         else if (enter)
            suspended <= 1'b1;
      end
   end
endmodule

// File: rtl/upc_iso_gate.sv
module upc_iso_gate #(
   parameter bit ISO_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic iso_upd,
   input  logic inhibit,
   input  logic iso_armed,
   input  logic sof_rx,
   input  logic in_tok,
   output logic iso_send,
   output logic iso_zlp,
   output logic iso_hold
);
   generate
      if (ISO_EN) begin : g_iso
         logic sof_seen;
         logic tok_ok;
         assign tok_ok   = in_tok && iso_armed && !inhibit;
         assign iso_send = tok_ok && (!iso_upd || sof_seen);
         assign iso_zlp  = tok_ok && iso_upd && !sof_seen;
         assign iso_hold = iso_upd && iso_armed && !sof_seen;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sof_seen <= 1'b0;
            else if (!iso_armed || !iso_upd || iso_send)
               sof_seen <= 1'b0;
            else if (sof_rx && !inhibit)
               sof_seen <= 1'b1;
         end
      end else begin : g_noiso
         logic unused;
         assign unused   = &{clk, rst_n, iso_upd, inhibit, iso_armed, sof_rx, in_tok};
         assign iso_send = 1'b0;
         assign iso_zlp  = 1'b0;
         assign iso_hold = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/usb_pwr_ctl.sv
module usb_pwr_ctl
   import usb_pwr_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter logic [7:0]  REG_ADDR = 8'h01,
   parameter bit          ISO_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_rd,
   output logic [7:0]        reg_rdata,
   input  logic              bus_suspend,
   input  logic              bus_resume,
   input  logic              bus_reset,
   input  logic              sof_rx,
   input  logic              in_tok,
   input  logic              iso_armed,
   input  logic              intreg_rd,
   output logic              usb_inhibit,
   output logic              suspended,
   output logic              wakeup_drive,
   output logic              func_reset,
   output logic              resume_irq,
   output logic              iso_send,
   output logic              iso_zlp,
   output logic              iso_hold
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 8) else $error("ADDR_W out of range");
      assert (ADDR_W == 8 || REG_ADDR < (8'd1 << ADDR_W)) else $error("REG_ADDR exceeds ADDR_W");
      assert (DATA_W == 8) else $error("register is 8 bits");
   end

   logic sel, wr_hit;
   logic iso_upd, rsm_bit, susen;
   logic unused_wd;

   assign sel       = (reg_addr == HIT_ADDR);
   assign wr_hit    = reg_wr && sel;
   assign unused_wd = &{reg_wdata[6:5], reg_wdata[1]};

   upc_ctrl_bits u_bits (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
      .wd_iso(reg_wdata[B_ISO]), .wd_inh(reg_wdata[B_INH]), .wd_rst(reg_wdata[B_RST]),
      .wd_rsm(reg_wdata[B_RSM]), .wd_susen(reg_wdata[B_SUSEN]),
      .iso_upd(iso_upd), .inhibit(usb_inhibit), .rsm_bit(rsm_bit),
      .susen(susen), .func_reset(func_reset)
   );

   upc_susp_fsm u_susp (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
      .wd_rst(reg_wdata[B_RST]), .wd_rsm(reg_wdata[B_RSM]),
      .susen(susen), .inhibit(usb_inhibit),
      .bus_suspend(bus_suspend), .bus_resume(bus_resume), .intreg_rd(intreg_rd),
      .suspended(suspended), .wakeup_drive(wakeup_drive), .resume_irq(resume_irq)
   );

   upc_iso_gate #(.ISO_EN(ISO_EN)) u_iso (
      .clk(clk), .rst_n(rst_n), .iso_upd(iso_upd), .inhibit(usb_inhibit),
      .iso_armed(iso_armed), .sof_rx(sof_rx), .in_tok(in_tok),
      .iso_send(iso_send), .iso_zlp(iso_zlp), .iso_hold(iso_hold)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_rd && sel) begin
         reg_rdata[B_ISO]   = iso_upd;
         reg_rdata[B_INH]   = usb_inhibit;
         reg_rdata[B_RST]   = bus_reset;
         reg_rdata[B_RSM]   = rsm_bit;
         reg_rdata[B_SUSP]  = suspended;
         reg_rdata[B_SUSEN] = susen;
      end
   end
endmodule

// File: rtl/upc_checker.sv
module upc_checker #(
   parameter int         ADDR_W   = 8,
   parameter logic [7:0] REG_ADDR = 8'h01
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        reg_rdata,
   input logic              bus_suspend,
   input logic              usb_inhibit,
   input logic              suspended,
   input logic              func_reset,
   input logic              resume_irq,
   input logic              iso_send,
   input logic              iso_zlp
);
   logic sw_rst;
   assign sw_rst = reg_wr && (reg_addr == ADDR_W'(REG_ADDR)) && reg_wdata[3];

   assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[6:5] == 2'b00);
   assert_inhibit_set_by_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(usb_inhibit) |-> $past(sw_rst));
   assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      func_reset |-> usb_inhibit);
   assert_reset_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      func_reset |=> !func_reset || $past(sw_rst));
   assert_suspend_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> $past(bus_suspend && !usb_inhibit));
   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resume_irq |-> !suspended);
   assert_iso_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(iso_send && iso_zlp));
   assert_iso_inhibit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      usb_inhibit |-> !(iso_send || iso_zlp));
endmodule

bind usb_pwr_ctl upc_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_suspend(bus_suspend),
   .usb_inhibit(usb_inhibit), .suspended(suspended), .func_reset(func_reset),
   .resume_irq(resume_irq), .iso_send(iso_send), .iso_zlp(iso_zlp)
);

// File: tb/usb_pwr_ctl_tb.sv
module usb_pwr_ctl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] reg_addr = 8'h01;
   logic reg_wr = 0, reg_rd = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic bus_suspend = 0, bus_resume = 0, bus_reset = 0, sof_rx = 0, in_tok = 0;
   logic iso_armed = 0, intreg_rd = 0;
   logic usb_inhibit, suspended, wakeup_drive, func_reset, resume_irq;
   logic iso_send, iso_zlp, iso_hold;
   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   usb_pwr_ctl u_dut (.*);

   // {wr, wdata[7:0], bus_suspend, bus_resume, intreg_rd, expected readback[7:0]}
   localparam int NV = 14;
   localparam logic [19:0] VEC [NV] = '{
      {1'b1, 8'h01, 3'b000, 8'h01},  // R3 clear inhibit, enable detect
      {1'b0, 8'h00, 3'b100, 8'h03},  // R5 enter suspend
      {1'b1, 8'h05, 3'b000, 8'h07},  // R6 start wakeup
      {1'b1, 8'h01, 3'b000, 8'h01},  // R6 end wakeup clears suspend
      {1'b0, 8'h00, 3'b100, 8'h03},  // R5 suspend again
      {1'b0, 8'h00, 3'b010, 8'h03},  // R8 bus resume latched
      {1'b0, 8'h00, 3'b001, 8'h01},  // R8 interrupt read clears suspend
      {1'b1, 8'h00, 3'b000, 8'h00},  // R5 disable detect
      {1'b0, 8'h00, 3'b100, 8'h00},  // R5 suspend ignored
      {1'b1, 8'hE6, 3'b000, 8'h84},  // R2 R7 unused/suspend bits ignored, resume reads back
      {1'b1, 8'h08, 3'b000, 8'h10},  // R4 soft reset
      {1'b1, 8'h11, 3'b100, 8'h11},  // R11 suspend ignored while inhibited
      {1'b1, 8'h01, 3'b000, 8'h01},  // R3 clear inhibit
      {1'b1, 8'h11, 3'b000, 8'h01}   // R3 cannot set inhibit
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd_reg(input logic [7:0] addr, output logic [7:0] val);
      reg_addr = addr; reg_rd = 1; #1; val = reg_rdata; reg_rd = 0; reg_addr = 8'h01;
   endtask

   task automatic wr_reg(input logic [7:0] addr, input logic [7:0] d);
      @(negedge clk); reg_addr = addr; reg_wr = 1; reg_wdata = d;
      @(negedge clk); reg_wr = 0; reg_addr = 8'h01;
   endtask

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      rd_reg(8'h01, v); chk("R2 reset value", v, 8'h10);
      chk("R3 reset inhibit", {7'd0, usb_inhibit}, 8'h01);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         reg_wr = VEC[i][19]; reg_wdata = VEC[i][18:11];
         bus_suspend = VEC[i][10]; bus_resume = VEC[i][9]; intreg_rd = VEC[i][8];
         @(negedge clk);
         if (i == 2) chk("R6 wakeup_drive on", {7'd0, wakeup_drive}, 8'h01);
         if (i == 3) chk("R6 resume_irq pulse", {7'd0, resume_irq}, 8'h01);
         if (i == 10) chk("R4 func_reset pulse", {7'd0, func_reset}, 8'h01);
         reg_wr = 0; bus_suspend = 0; bus_resume = 0; intreg_rd = 0;
         if (i == 9) chk("R7 no wakeup when awake", {7'd0, wakeup_drive}, 8'h00);
         rd_reg(8'h01, v); chk($sformatf("vector %0d", i), v, VEC[i][7:0]);
      end
      chk("R4 func_reset one cycle", {7'd0, func_reset}, 8'h00);

      // R7: clearing a resume bit written while awake raises no interrupt
      wr_reg(8'h01, 8'h05);
      wr_reg(8'h01, 8'h01);
      chk("R7 no irq", {7'd0, resume_irq}, 8'h00);
      @(negedge clk); chk("R7 no irq later", {7'd0, resume_irq}, 8'h00);

      // R1: other address
      wr_reg(8'h02, 8'h00);
      rd_reg(8'h01, v); chk("R1 foreign write ignored", v, 8'h01);
      rd_reg(8'h02, v); chk("R1 foreign read zero", v, 8'h00);

      // R4: live bus reset readback
      bus_reset = 1; rd_reg(8'h01, v); chk("R4 bus reset read", v, 8'h09);
      bus_reset = 0;

      // R9: iso update off, immediate send
      iso_armed = 1;
      @(negedge clk); in_tok = 1; #1;
      chk("R9 send on IN", {6'd0, iso_send, iso_zlp}, 8'h02);
      @(negedge clk); in_tok = 0;

      // R10: iso update on
      wr_reg(8'h01, 8'h81);
      chk("R10 hold before SOF", {7'd0, iso_hold}, 8'h01);
      in_tok = 1; #1;
      chk("R10 zlp before SOF", {6'd0, iso_send, iso_zlp}, 8'h01);
      @(negedge clk); in_tok = 0; sof_rx = 1;
      @(negedge clk); sof_rx = 0;
      chk("R10 hold released", {7'd0, iso_hold}, 8'h00);
      in_tok = 1; #1;
      chk("R10 send after SOF", {6'd0, iso_send, iso_zlp}, 8'h02);
      @(negedge clk); in_tok = 0;
      chk("R10 hold rearmed", {7'd0, iso_hold}, 8'h01);

      // R11: inhibited IN token ignored
      wr_reg(8'h01, 8'h08);
      in_tok = 1; #1;
      chk("R11 IN ignored", {6'd0, iso_send, iso_zlp}, 8'h00);
      @(negedge clk); in_tok = 0; iso_armed = 0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule